// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Buffer

This block holds incoming data for one isochronous OUT endpoint of a USB device controller. A serial interface engine that has already decoded the bus hands it packets as a start strobe, a run of byte-valid strobes with data, and an end-of-packet strobe that carries a CRC-good flag. The block keeps two packet buffers that take turns. A packet becomes visible to the CPU only after it has passed the CRC check. A packet that arrives while both buffers are occupied is dropped whole, and that drop is recorded.

The CPU pulls bytes one at a time through a pop strobe and a read-data port, oldest packet first. It watches progress through a 32-bit status/control word. That word has read-only flags for packet-ready, data-present and short-packet, sticky write-one-to-clear flags for packet-done and overflow, and a read/write DMA-mode bit. An interrupt output combines the sticky flags with an enable input. In DMA mode the interrupt is further held back until the buffered byte count drops below a low-water mark.

Top module: `iso_out_rxbuf`

## Requirements
- R1: After reset, `csr_rdata` reads 0 and `irq` is 0.
- R2: Bytes of a packet accepted with CRC good come out on `rd_data` in arrival order, oldest packet first. Each `rd_en` pulse advances one byte. A packet keeps at most `MAX_PKT` (256) bytes, and any further bytes are discarded.
- R3: Bit 0 (ready) is 1 while at least one validated packet is held. It returns to 0 once every held packet has been fully read.
- R4: Bit 1 (done) is set by every end-of-packet strobe, whether the packet was good, bad or dropped. Writing 1 to it clears it and writing 0 leaves it unchanged. An end-of-packet in the same cycle as a clearing write leaves it set.
- R5: Bit 2 (overflow) is set when a packet starts while both buffers are occupied. The flag shows at that packet's end, and none of the packet's bytes are stored. It is cleared the same way as bit 1, and a new set wins over a clearing write in the same cycle.
- R6: Bit 3 (DMA mode) reads back the last value written to it. Bits 5:4 and 31:8 always read 0.
- R7: Bit 6 (data present) is 1 exactly when the buffered, unread byte count is nonzero.
- R8: Bit 7 (short) is 1 when the oldest held packet has fewer than `MAX_PKT` bytes, which includes a zero-length packet.
- R9: A packet that ends with CRC-good low is discarded. Its buffer is freed and only bit 1 changes.
- R10: `irq` = `irq_en` AND (overflow OR (done AND (DMA mode = 0 OR buffered bytes < `LOW_MARK` (32)))).
- R11: A zero-length packet occupies a whole buffer and sets bits 0 and 7 while bit 6 stays 0. A single `rd_en` pulse consumes it.
- R12: The buffers are claimed and drained alternately. A buffer freed by a read in the same cycle as a start strobe is not available to that packet, so the packet is dropped. `sie_eop` always comes at least one cycle after the last `sie_valid` and after `sie_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sie_start | input | 1 | Start of an OUT data packet |
| sie_valid | input | 1 | `sie_data` carries a packet byte |
| sie_data | input | 8 | Packet byte |
| sie_eop | input | 1 | End of packet |
| sie_crc_ok | input | 1 | CRC result, sampled with `sie_eop` |
| rd_en | input | 1 | Pop one byte (or one zero-length packet) |
| rd_data | output | 8 | Byte at the head of the oldest held packet |
| csr_wr | input | 1 | Write strobe for the status/control word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Status/control word |
| irq_en | input | 1 | Endpoint receive interrupt enable |
| irq | output | 1 | Endpoint receive interrupt |

## Verification
A behavioural model built from byte and length queues is compared with the block on every clock. The stimulus covers short, exactly-full and oversized packets, which separate correct length tracking from truncation. Zero-length and bad-CRC packets show that occupancy is kept apart from the byte count. Three back-to-back packets, and a start strobe landing on the cycle a read frees a buffer, exercise the drop path and the decision to sample buffer state before the update. A DMA-mode packet drained one byte at a time around the 32-byte mark pins down the exact threshold, and clearing writes placed on an end-of-packet cycle confirm that a set wins.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

   typedef enum logic [1:0] {
      BUF_FREE = 2'd0,
      BUF_FILL = 2'd1,
      BUF_FULL = 2'd2
   } buf_st_e;

   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_FILL = 2'd1,
      RX_DROP = 2'd2
   } rx_mode_e;

   localparam int B_READY  = 0;
   localparam int B_DONE   = 1;
   localparam int B_OVF    = 2;
   localparam int B_DMA    = 3;
   localparam int B_NEMPTY = 6;
   localparam int B_SHORT  = 7;

endpackage

// File: rtl/iso_rx_bank.sv
module iso_rx_bank #(
   parameter int DEPTH = 256,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/iso_rx_ctl.sv
module iso_rx_ctl
   import iso_rx_pkg::*;
#(
   parameter int MAX_PKT = 256,
   parameter int LEN_W   = $clog2(MAX_PKT + 1),
   parameter int LVL_W   = LEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sie_start,
   input  logic             sie_valid,
   input  logic             sie_eop,
   input  logic             sie_crc_ok,
   input  logic             rd_en,
   output logic [1:0]       wr_en,
   output logic [LEN_W-1:0] wr_cnt,
   output logic             rd_sel,
   output logic [LEN_W-1:0] rd_idx,
   output logic             pkt_done,
   output logic             drop_evt,
   output logic             has_pkt,
   output logic             head_short,
   output logic [LVL_W-1:0] level
);

   localparam logic [LEN_W-1:0] MAX_V = LEN_W'(MAX_PKT);
   localparam int NBUF = 2;

   buf_st_e          st  [NBUF];
   logic [LEN_W-1:0] len [NBUF];
   logic             wr_ptr;
   logic             rd_ptr;
   rx_mode_e         mode;

   logic head_full, claim, commit, abandon, pop, pop_last, wr_go;
   logic [LEN_W-1:0] rem_head, rem_other;

   assign head_full = (st[rd_ptr] == BUF_FULL);
   assign claim     = sie_start && (st[wr_ptr] == BUF_FREE);
   assign commit    = sie_eop && (mode == RX_FILL) && sie_crc_ok;
   assign abandon   = sie_eop && (mode == RX_FILL) && !sie_crc_ok;
   assign pop       = rd_en && head_full;
   assign pop_last  = pop && ((len[rd_ptr] == '0) || (rd_idx == len[rd_ptr] - 1'b1));
   assign wr_go     = sie_valid && (mode == RX_FILL) && (wr_cnt < MAX_V);

   // receive mode and byte count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= RX_IDLE;
         wr_cnt <= '0;
      end else begin
         if (sie_start) begin
            mode   <= claim ? RX_FILL : RX_DROP;
            wr_cnt <= '0;
         end else if (sie_eop) begin
            mode   <= RX_IDLE;
         end else if (wr_go) begin
            wr_cnt <= wr_cnt + 1'b1;
         end
      end
   end

   // pointers: fill and drain alternate between the two buffers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= 1'b0;
         rd_ptr <= 1'b0;
         rd_idx <= '0;
      end else begin
         if (commit) wr_ptr <= ~wr_ptr;
         if (pop_last) begin
            rd_ptr <= ~rd_ptr;
            rd_idx <= '0;
         end else if (pop) begin
            rd_idx <= rd_idx + 1'b1;
         end
      end
   end

   for (genvar b = 0; b < NBUF; b++) begin : g_buf
      logic at_wr, at_rd;
      assign at_wr    = (wr_ptr == 1'(b));
      assign at_rd    = (rd_ptr == 1'(b));
      assign wr_en[b] = wr_go && at_wr;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st[b]  <= BUF_FREE;
            len[b] <= '0;
         end else if (claim && at_wr) begin
            st[b]  <= BUF_FILL;
         end else if (commit && at_wr) begin
            st[b]  <= BUF_FULL;
            len[b] <= wr_cnt;
         end else if (abandon && at_wr) begin
            st[b]  <= BUF_FREE;
         end else if (pop_last && at_rd) begin
            st[b]  <= BUF_FREE;
         end
      end
   end

   assign rem_head   = head_full ? (len[rd_ptr] - rd_idx) : '0;
   assign rem_other  = (st[~rd_ptr] == BUF_FULL) ? len[~rd_ptr] : '0;
   assign level      = LVL_W'(rem_head) + LVL_W'(rem_other);
   assign has_pkt    = (st[0] == BUF_FULL) || (st[1] == BUF_FULL);
   assign head_short = head_full && (len[rd_ptr] < MAX_V);
   assign rd_sel     = rd_ptr;
   assign pkt_done   = sie_eop;
   assign drop_evt   = sie_eop && (mode == RX_DROP);

endmodule

// File: rtl/iso_rx_csr.sv
module iso_rx_csr
   import iso_rx_pkg::*;
#(
   parameter int LVL_W    = 10,
   parameter int LOW_MARK = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_wr,
   input  logic [31:0]      csr_wdata,
   input  logic             pkt_done,
   input  logic             drop_evt,
   input  logic             has_pkt,
   input  logic             head_short,
   input  logic [LVL_W-1:0] level,
   input  logic             irq_en,
   output logic [31:0]      csr_rdata,
   output logic             irq
);

   localparam logic [LVL_W-1:0] LOW_V = LVL_W'(LOW_MARK);

   logic done_q, ovf_q, dma_q;
   logic clr_done, clr_ovf;
   logic unused_wdata;

   assign clr_done     = csr_wr && csr_wdata[B_DONE];
   assign clr_ovf      = csr_wr && csr_wdata[B_OVF];
   assign unused_wdata = ^{csr_wdata[31:4], csr_wdata[B_READY]};

   // sticky flags: a set event outranks a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
         dma_q  <= 1'b0;
      end else begin
         done_q <= pkt_done || (done_q && !clr_done);
         ovf_q  <= drop_evt || (ovf_q && !clr_ovf);
         if (csr_wr) dma_q <= csr_wdata[B_DMA];
      end
   end

   always_comb begin
      csr_rdata           = '0;
      csr_rdata[B_READY]  = has_pkt;
      csr_rdata[B_DONE]   = done_q;
      csr_rdata[B_OVF]    = ovf_q;
      csr_rdata[B_DMA]    = dma_q;
      csr_rdata[B_NEMPTY] = (level != '0);
      csr_rdata[B_SHORT]  = head_short;
   end

   assign irq = irq_en && (ovf_q || (done_q && (!dma_q || (level < LOW_V))));

endmodule

// File: rtl/iso_out_rxbuf.sv
module iso_out_rxbuf #(
   parameter int MAX_PKT  = 256,
   parameter int LOW_MARK = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sie_start,
   input  logic        sie_valid,
   input  logic [7:0]  sie_data,
   input  logic        sie_eop,
   input  logic        sie_crc_ok,
   input  logic        rd_en,
   output logic [7:0]  rd_data,
   input  logic        csr_wr,
   input  logic [31:0] csr_wdata,
   output logic [31:0] csr_rdata,
   input  logic        irq_en,
   output logic        irq
);

   localparam int IDX_W = $clog2(MAX_PKT);
   localparam int LEN_W = $clog2(MAX_PKT + 1);
   localparam int LVL_W = LEN_W + 1;

   if (MAX_PKT < 2) begin : g_bad_max
      $error("iso_out_rxbuf: MAX_PKT must be at least 2");
   end
   if (LOW_MARK < 1 || LOW_MARK > 2 * MAX_PKT) begin : g_bad_mark
      $error("iso_out_rxbuf: LOW_MARK must lie in 1..2*MAX_PKT");
   end

   logic [1:0]       wr_en;
   logic [LEN_W-1:0] wr_cnt;
   logic             rd_sel;
   logic [LEN_W-1:0] rd_idx;
   logic             pkt_done, drop_evt, has_pkt, head_short;
   logic [LVL_W-1:0] level;
   logic [7:0]       bank_q [2];

   iso_rx_ctl #(
      .MAX_PKT (MAX_PKT),
      .LEN_W   (LEN_W),
      .LVL_W   (LVL_W)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sie_start  (sie_start),
      .sie_valid  (sie_valid),
      .sie_eop    (sie_eop),
      .sie_crc_ok (sie_crc_ok),
      .rd_en      (rd_en),
      .wr_en      (wr_en),
      .wr_cnt     (wr_cnt),
      .rd_sel     (rd_sel),
      .rd_idx     (rd_idx),
      .pkt_done   (pkt_done),
      .drop_evt   (drop_evt),
      .has_pkt    (has_pkt),
      .head_short (head_short),
      .level      (level)
   );

   for (genvar b = 0; b < 2; b++) begin : g_bank
      iso_rx_bank #(
         .DEPTH (MAX_PKT),
         .IDX_W (IDX_W)
      ) u_bank (
         .clk     (clk),
         .wr_en   (wr_en[b]),
         .wr_idx  (wr_cnt[IDX_W-1:0]),
         .wr_data (sie_data),
         .rd_idx  (rd_idx[IDX_W-1:0]),
         .rd_data (bank_q[b])
      );
   end

   assign rd_data = bank_q[rd_sel];

   iso_rx_csr #(
      .LVL_W    (LVL_W),
      .LOW_MARK (LOW_MARK)
   ) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .csr_wr     (csr_wr),
      .csr_wdata  (csr_wdata),
      .pkt_done   (pkt_done),
      .drop_evt   (drop_evt),
      .has_pkt    (has_pkt),
      .head_short (head_short),
      .level      (level),
      .irq_en     (irq_en),
      .csr_rdata  (csr_rdata),
      .irq        (irq)
   );

endmodule

// File: rtl/iso_out_rxbuf_chk.sv
module iso_out_rxbuf_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sie_eop,
   input logic        csr_wr,
   input logic [31:0] csr_wdata,
   input logic [31:0] csr_rdata,
   input logic        irq_en,
   input logic        irq
);

   // R4
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sie_eop |=> csr_rdata[1]);

   // R4
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && csr_wdata[1] && !sie_eop) |=> !csr_rdata[1]);

   // R5
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata[2] && !(csr_wr && csr_wdata[2])) |=> csr_rdata[2]);

   // R6
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata[31:8] == 24'd0) && (csr_rdata[5:4] == 2'd0));

   // R7
   nempty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[6] |-> csr_rdata[0]);

   // R8
   short_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[7] |-> csr_rdata[0]);

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && (csr_rdata[1] || csr_rdata[2])));

endmodule

bind iso_out_rxbuf iso_out_rxbuf_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sie_eop   (sie_eop),
   .csr_wr    (csr_wr),
   .csr_wdata (csr_wdata),
   .csr_rdata (csr_rdata),
   .irq_en    (irq_en),
   .irq       (irq)
);

// File: tb/iso_out_rxbuf_tb.sv
module iso_out_rxbuf_tb;

   localparam int MAX = 256;
   localparam int LOW = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sie_start = 0, sie_valid = 0, sie_eop = 0, sie_crc_ok = 0;
   logic [7:0]  sie_data = '0;
   logic        rd_en = 0;
   logic [7:0]  rd_data;
   logic        csr_wr = 0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        irq_en = 0;
   logic        irq;

   always #2.5 clk = ~clk;

   iso_out_rxbuf #(.MAX_PKT(MAX), .LOW_MARK(LOW)) u_dut (
      .clk(clk), .rst_n(rst_n), .sie_start(sie_start), .sie_valid(sie_valid),
      .sie_data(sie_data), .sie_eop(sie_eop), .sie_crc_ok(sie_crc_ok),
      .rd_en(rd_en), .rd_data(rd_data), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .irq_en(irq_en), .irq(irq)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   logic [7:0] m_data [$];
   int         m_len  [$];
   logic [7:0] m_cur  [$];
   int         m_mode = 0;   // 0 idle, 1 storing, 2 dropping
   int         m_hc = 0;
   bit         m_done = 0, m_ovf = 0, m_dma = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_data.delete(); m_len.delete(); m_cur.delete();
         m_mode = 0; m_hc = 0; m_done = 0; m_ovf = 0; m_dma = 0;
      end else begin
         bit eop_now;
         int eop_mode;
         eop_now  = sie_eop;
         eop_mode = m_mode;
         if (sie_start) begin
            m_mode = (m_len.size() < 2) ? 1 : 2;
            m_cur.delete();
         end
         if (sie_valid && m_mode == 1 && m_cur.size() < MAX) m_cur.push_back(sie_data);
         if (rd_en && m_len.size() > 0) begin
            if (m_len[0] == 0) begin
               void'(m_len.pop_front());
            end else begin
               void'(m_data.pop_front());
               m_hc++;
               if (m_hc == m_len[0]) begin
                  void'(m_len.pop_front());
                  m_hc = 0;
               end
            end
         end
         if (csr_wr) begin
            m_dma = csr_wdata[3];
            if (csr_wdata[1]) m_done = 0;
            if (csr_wdata[2]) m_ovf = 0;
         end
         if (eop_now) begin
            m_done = 1;
            if (eop_mode == 1 && sie_crc_ok) begin
               m_len.push_back(m_cur.size());
               foreach (m_cur[i]) m_data.push_back(m_cur[i]);
            end
            if (eop_mode == 2) m_ovf = 1;
            m_mode = 0;
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e_irq;
         e_irq = irq_en && (m_ovf || (m_done && (!m_dma || m_data.size() < LOW)));
         check("R3 ready",    32'(csr_rdata[0]), 32'(m_len.size() > 0));
         check("R4 done",     32'(csr_rdata[1]), 32'(m_done));
         check("R5 overflow", 32'(csr_rdata[2]), 32'(m_ovf));
         check("R6 dma",      32'(csr_rdata[3]), 32'(m_dma));
         check("R6 reserved", {csr_rdata[31:8], 2'b00, csr_rdata[5:4], 4'h0}, 32'd0);
         check("R7 nempty",   32'(csr_rdata[6]), 32'(m_data.size() > 0));
         check("R8 short",    32'(csr_rdata[7]), 32'(m_len.size() > 0 && m_len[0] < MAX));
         check("R10 irq",     32'(irq), 32'(e_irq));
         if (m_len.size() > 0 && m_len[0] > 0)
            check("R2 rd_data", 32'(rd_data), 32'(m_data[0]));
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic send_pkt(int n, bit crc, int seed, bit clr_at_eop = 0);
      sie_start = 1; tick(); sie_start = 0;
      for (int i = 0; i < n; i++) begin
         sie_valid = 1; sie_data = 8'(seed + i * 3); tick();
      end
      sie_valid = 0;
      sie_eop = 1; sie_crc_ok = crc;
      if (clr_at_eop) begin csr_wr = 1; csr_wdata = 32'h6; end
      tick();
      sie_eop = 0; sie_crc_ok = 0; csr_wr = 0; csr_wdata = '0;
   endtask

   task automatic read_n(int n);
      for (int i = 0; i < n; i++) begin
         rd_en = 1; tick();
      end
      rd_en = 0;
   endtask

   task automatic csr_write(logic [31:0] v);
      csr_wr = 1; csr_wdata = v; tick(); csr_wr = 0; csr_wdata = '0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      // R1 reset state
      check("R1 csr after reset", csr_rdata, 32'd0);
      check("R1 irq after reset", 32'(irq), 32'd0);

      irq_en = 1;
      send_pkt(10, 1, 8'h20);
      check("R3 ready after good packet", 32'(csr_rdata[0]), 1);
      check("R10 irq on completion", 32'(irq), 1);
      csr_write(32'h0);
      check("R4 write 0 keeps done", 32'(csr_rdata[1]), 1);
      csr_write(32'h2);
      check("R4 write 1 clears done", 32'(csr_rdata[1]), 0);
      read_n(10);
      check("R3 ready after drain", 32'(csr_rdata[0]), 0);

      // R9 bad CRC
      send_pkt(5, 0, 8'h40);
      check("R9 bad packet not ready", 32'(csr_rdata[0]), 0);
      check("R9 bad packet no data", 32'(csr_rdata[6]), 0);
      check("R9 bad packet done", 32'(csr_rdata[1]), 1);

      // R11 zero-length packet
      send_pkt(0, 1, 0);
      check("R11 zero ready", 32'(csr_rdata[0]), 1);
      check("R11 zero short", 32'(csr_rdata[7]), 1);
      check("R11 zero nempty", 32'(csr_rdata[6]), 0);
      read_n(1);
      check("R11 zero consumed", 32'(csr_rdata[0]), 0);

      // R8 / R2 full and oversized packets
      send_pkt(256, 1, 8'h05);
      check("R8 full packet not short", 32'(csr_rdata[7]), 0);
      read_n(256);
      send_pkt(260, 1, 8'h77);
      read_n(256);
      check("R2 oversized truncated", 32'(csr_rdata[0]), 0);

      // R5 overflow
      send_pkt(4, 1, 8'h10);
      send_pkt(4, 1, 8'h30);
      send_pkt(4, 1, 8'h50);
      check("R5 overflow set", 32'(csr_rdata[2]), 1);
      read_n(8);
      check("R5 dropped packet absent", 32'(csr_rdata[0]), 0);
      csr_write(32'h4);
      check("R5 overflow cleared", 32'(csr_rdata[2]), 0);

      // R4 set wins over clear
      csr_write(32'h2);
      send_pkt(3, 1, 8'h90, 1);
      check("R4 set wins", 32'(csr_rdata[1]), 1);
      read_n(3);

      // R10 DMA mode threshold
      csr_write(32'hA);
      check("R6 dma readback", 32'(csr_rdata[3]), 1);
      send_pkt(40, 1, 8'hA0);
      check("R10 dma irq held at 40", 32'(irq), 0);
      read_n(8);
      check("R10 dma irq held at 32", 32'(irq), 0);
      read_n(1);
      check("R10 dma irq at 31", 32'(irq), 1);
      read_n(31);
      csr_write(32'h2);

      // R12 start on the cycle a read frees a buffer
      send_pkt(1, 1, 8'h11);
      send_pkt(1, 1, 8'h22);
      sie_start = 1; rd_en = 1; tick();
      sie_start = 0; rd_en = 0;
      sie_valid = 1; sie_data = 8'h33; tick(); sie_valid = 0;
      sie_eop = 1; sie_crc_ok = 1; tick(); sie_eop = 0; sie_crc_ok = 0;
      check("R12 drop despite same-cycle free", 32'(csr_rdata[2]), 1);
      check("R12 second packet remains", 32'(rd_data), 32'h22);
      irq_en = 0;
      tick();
      check("R10 irq masked", 32'(irq), 0);
      read_n(1);
      check("R12 drained", 32'(csr_rdata[0]), 0);

      tick();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         done = 1;
         n_err++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule